// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM that stores one bit per location and has separate data-in and data-out pins. The host offers one request at a time over a valid/ready handshake: a direction flag, an address and, for writes, a single data bit. The controller then drives the memory's active-low chip enable and write enable, its address bus and its data-in line, all from registers. Every timing minimum of the memory is expressed as a count of clock cycles.

A write selects the chip for one cycle with write enable high. It then pulls write enable low for the programmed pulse length. Both enables are released on the same edge, and the controller waits out a recovery gap so that the memory's write cycle time is met. A read selects the chip with write enable high and waits the access time in cycles. It captures the data-out pin on the last of those edges, while the pin is still driven. The controller then deselects the chip and returns the bit to the host with a one-cycle valid strobe.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While reset is asserted, mem_ce_n and mem_we_n are 1, req_ready is 0 and rd_valid is 0. After release the block is idle with req_ready at 1 and the memory deselected.
- R2: req_ready is 1 only while idle. It falls on the edge that accepts a request and stays 0 until that access has fully completed. The memory is never selected while req_ready is 1.
- R3: A write holds mem_ce_n low with mem_we_n high for one cycle. It then drives mem_we_n low for exactly PULSE_CYC consecutive cycles.
- R4: A write is closed by mem_we_n and mem_ce_n rising on the same clock edge. mem_addr and mem_din do not change during any cycle in which mem_ce_n stays low.
- R5: After a write, the next falling edge of mem_ce_n comes no sooner than CYCLE_CYC cycles after the falling edge that began the write.
- R6: A read holds mem_ce_n low and mem_we_n high for ACCESS_CYC cycles. mem_dout is captured on the last of those edges, the same edge that deselects the chip. rd_valid is a single-cycle pulse, visible ACCESS_CYC cycles after the accepting edge, and rd_data holds the bit last written to that address.
- R7: mem_we_n is low only while mem_ce_n is low.
- R8: rd_valid is never raised during or because of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle strobe marking rd_data |
| rd_data | output | 1 | Bit read from memory |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_din | output | 1 | Memory data-in line |
| mem_dout | input | 1 | Memory data-out line (high-impedance when not reading) |

## Verification
The hardest case to produce from the ports is a capture that is off by one cycle. The memory drives some value on mem_dout early, so a read that samples too soon may still return the right bit. The bench's memory model therefore drives an unknown level on mem_dout until chip enable has been low, with write enable high, for one cycle less than the access count. A premature capture then shows up as an unknown rd_data. A full sweep that writes each address and reads it back, in two passes with opposite data patterns, catches stale or misrouted bits.

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl #(
  parameter int ADDR_W     = 18,
  parameter int PULSE_CYC  = 1,
  parameter int ACCESS_CYC = 2,
  parameter int CYCLE_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  input  logic              mem_dout
);

  localparam int REC_CYC = (CYCLE_CYC > PULSE_CYC + 2) ? CYCLE_CYC - PULSE_CYC - 2 : 1;
  localparam int MAX_A   = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
  localparam int MAX_C   = (MAX_A > REC_CYC) ? MAX_A : REC_CYC;
  localparam int CW      = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] ACC_LD   = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] REC_LD   = CW'(REC_CYC - 1);

  generate
    if (PULSE_CYC < 1 || ACCESS_CYC < 1 || CYCLE_CYC < 1) begin : g_bad_timing
      $error("sram_seq_ctrl: cycle counts must be at least 1");
    end
  endgenerate

  typedef enum logic [2:0] {
    IDLE, WR_SETUP, WR_PULSE, WR_RECOVER, RD_ACCESS, RD_CAPTURE
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  wire           cnt_done = (cnt == '0);

  assign req_ready = (st == IDLE) && rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_addr <= '0;
      mem_din  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_write) begin
            mem_din <= req_wdata;
            st      <= WR_SETUP;
          end else begin
            cnt <= ACC_LD;
            st  <= RD_ACCESS;
          end
        end
        WR_SETUP: begin
          mem_we_n <= 1'b0;
          cnt      <= PULSE_LD;
          st       <= WR_PULSE;
        end
        WR_PULSE: if (cnt_done) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          cnt      <= REC_LD;
          st       <= WR_RECOVER;
        end else cnt <= cnt - 1'b1;
        WR_RECOVER: if (cnt_done) st <= IDLE;
                    else cnt <= cnt - 1'b1;
        RD_ACCESS: if (cnt_done) begin
          rd_data  <= mem_dout;
          rd_valid <= 1'b1;
          mem_ce_n <= 1'b1;
          st       <= RD_CAPTURE;
        end else cnt <= cnt - 1'b1;
        RD_CAPTURE: st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  p_idle_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n));
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_we_under_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_close_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> $rose(mem_ce_n));
  p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_din)));
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  p_strobe_deselects_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($rose(mem_ce_n) && mem_we_n));
  p_no_strobe_writing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !rd_valid);

endmodule

// File: tb/sim_sram_seq_ctrl.sv
module sim_sram_seq_ctrl;
  localparam int AW = 4;
  localparam int P  = 2;
  localparam int A  = 3;
  localparam int C  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wdata = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, rd_valid, rd_data, mem_ce_n, mem_we_n, mem_din;
  logic [AW-1:0] mem_addr;
  wire  mem_dout;

  int checks = 0, errors = 0;
  bit cur_wr = 1'b0;

  always #5 clk = ~clk;

  sram_seq_ctrl #(.ADDR_W(AW), .PULSE_CYC(P), .ACCESS_CYC(A), .CYCLE_CYC(C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout));

  // memory model: write lands when the enable overlap ends; output unknown until access time
  logic mem [0:(1<<AW)-1];
  wire  wr_on = !mem_ce_n && !mem_we_n;
  int   acc = 0;
  always @(negedge wr_on) if (rst_n) mem[mem_addr] = mem_din;
  always @(posedge clk) acc <= (!mem_ce_n && mem_we_n) ? acc + 1 : 0;
  assign mem_dout = (mem_ce_n || !mem_we_n) ? 1'bz : (acc >= A - 1) ? mem[mem_addr] : 1'bx;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int a, input int pass);
    return logic'((a ^ (a >> 1) ^ (a >> 3) ^ pass) & 1);
  endfunction

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_wr = wr;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 ready low after accept", req_ready, 0);
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic exp);
    int lat = 0;
    issue(1'b0, a, 1'b0);
    while (!rd_valid && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == A, "R6 read latency", lat, A);
    chk(rd_data === exp, "R6 read data", rd_data, exp);
  endtask

  // port monitor
  int wl = 0, since_fall = 0;
  logic pce = 1'b1, pwe = 1'b1, prv = 1'b0, pd = 1'b0, was_wr = 1'b0;
  logic [AW-1:0] pa = '0;
  always @(negedge clk) if (rst_n) begin
    since_fall++;
    if (!mem_we_n) begin
      wl++; was_wr = 1'b1;
      chk(!mem_ce_n, "R7 we low only under ce", mem_ce_n, 0);
    end
    if (mem_we_n && !pwe) begin
      chk(wl == P, "R3 write pulse length", wl, P);
      chk(mem_ce_n, "R4 ce closes with we", mem_ce_n, 1);
      wl = 0;
    end
    if (!mem_we_n && pwe) chk(!pce, "R3 setup cycle before pulse", pce, 0);
    if (!mem_ce_n && pce) begin
      if (was_wr) chk(since_fall >= C, "R5 write cycle time", since_fall, C);
      since_fall = 0; was_wr = 1'b0;
    end
    if (!mem_ce_n && !pce)
      chk(mem_addr == pa && mem_din == pd, "R4 bus stable while selected", {mem_addr, mem_din}, {pa, pd});
    if (!mem_ce_n) chk(!req_ready, "R2 ready low while selected", req_ready, 0);
    if (rd_valid) chk(!prv, "R6 strobe single cycle", prv, 0);
    if (cur_wr) chk(!rd_valid, "R8 no strobe on write", rd_valid, 0);
    pce = mem_ce_n; pwe = mem_we_n; prv = rd_valid; pa = mem_addr; pd = mem_din;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 1'b1; req_write = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n, "R1 enables high in reset", {mem_ce_n, mem_we_n}, 2'b11);
    chk(!req_ready && !rd_valid, "R1 ready and strobe low in reset", {req_ready, rd_valid}, 0);
    req_valid = 1'b0; req_write = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n, "R1 idle after release", {req_ready, mem_ce_n, mem_we_n}, 3'b111);

    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < (1 << AW); a++) issue(1'b1, AW'(a), pat(a, pass));
      for (int a = 0; a < (1 << AW); a++) read_chk(AW'(a), pat(a, pass));
    end
    for (int a = 0; a < (1 << AW); a++) begin
      issue(1'b1, AW'(a), ~pat(a, 0));
      read_chk(AW'(a), ~pat(a, 0));
    end
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule